// File: doc/BRIEF.md
# Sector Buffered Program Controller

This block is a clock-synchronous model of the program engine of a sector-erasable byte-wide flash memory. The host writes bytes. Each write carries a byte address, split into a sector number and an offset within the 256-byte sector. The first write opens a load phase, fixes the target sector and stores the byte in a sector-sized staging buffer. Later writes to the same sector may come in any order and may overwrite earlier ones.

No start command exists. When no accepted write arrives for a fixed number of clock cycles, the load phase closes on its own and a timed erase-then-program cycle begins. This cycle first sets the whole sector in the behavioural array to all ones, then writes the staged bytes into it. Offsets that were not loaded keep the erased value. While the cycle runs, `busy_o` is high and reads return a status pattern instead of array data: an inverted copy of bit 7 of the last loaded byte, and a bit that flips on every read. Software polls either bit to detect the end of the cycle. Clock-cycle counts stand in for the real load window and cycle time.

Top module: `sector_prog_ctrl`

## Requirements
- R1: Address bits [SECT_AW+7:8] select the sector and bits [7:0] select the byte. A write while idle fixes the sector and raises `load_o` from the next cycle.
- R2: Within one load phase, bytes may be written at any offset in any order. After programming, each loaded offset reads back the last value written to it.
- R3: `busy_o` rises exactly LOAD_WIN cycles after the last accepted write when no accepted write follows. A write arriving LOAD_WIN cycles or fewer after the previous one is accepted and restarts the window.
- R4: `busy_o` stays high for exactly PROG_CYC clock cycles and then returns low, back to idle.
- R5: After programming, offsets of the sector that were not loaded read 8'hFF, and all other sectors keep their contents.
- R6: A read sampled while busy returns bit 7 equal to the inverse of bit 7 of the last accepted write data, with bits 5:0 equal to zero.
- R7: Bit 6 of busy-status reads is 0 on the first read of a cycle and inverts on each further read. Once idle, repeated reads return true array data.
- R8: A write to a different sector during the load phase is ignored. It does not store data and does not restart the window, and it sets `sect_err_o`, which stays high until reset.
- R9: Writes while busy are ignored. They change neither the array nor the status bit 7, and they do not set `sect_err_o`.
- R10: After reset `busy_o`, `load_o`, `sect_err_o` and `rdata_o` are 0, and every array byte reads 8'hFF.
- R11: `rdata_o` takes the read result at the clock edge that samples `re_i` and holds it until the next sampled read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Byte write strobe |
| re_i | input | 1 | Read strobe |
| addr_i | input | SECT_AW+8 | Byte address: sector in the high bits, offset in the low 8 bits |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data or busy status |
| busy_o | output | 1 | Erase-and-program cycle in progress |
| load_o | output | 1 | Load phase open |
| sect_err_o | output | 1 | Sticky flag for a write to a foreign sector during loading |

## Verification
The assertions assume `we_i` and `re_i` are single-cycle strobes sampled at the clock edge, and that `addr_i` is valid whenever either strobe is high. They also assume PROG_CYC is at least twice the sector size, so that both array passes fit inside the cycle. The stimulus drives every input on the falling edge and holds each strobe for one cycle only. Gaps between writes are drawn from 0 to LOAD_WIN-1 idle cycles, so random loads never close early. The window edge, the foreign-sector write and the write while busy are placed by directed cases at known cycle offsets.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int BYTE_AW = 8;
  localparam int DW      = 8;
  localparam int NB      = 1 << BYTE_AW;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } spc_state_e;
endpackage

// File: rtl/spc_sector_buf.sv
module spc_sector_buf
  import spc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [BYTE_AW-1:0] wr_idx_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic               clr_i,
  input  logic [BYTE_AW-1:0] rd_idx_i,
  output logic [DW-1:0]      rd_data_o,
  output logic               rd_valid_o
);
  logic [DW-1:0] mem_q [NB];
  logic [NB-1:0] vld_q;

  // data needs no reset: it is masked by the valid bits
  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vld_q <= '0;
    else if (clr_i) vld_q <= '0;
    else if (wr_i)  vld_q[wr_idx_i] <= 1'b1;
  end

  assign rd_data_o  = mem_q[rd_idx_i];
  assign rd_valid_o = vld_q[rd_idx_i];

  a_r8_no_clr_and_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && wr_i));
endmodule

// File: rtl/spc_flash_array.sv
module spc_flash_array
  import spc_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cell_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
    end else if (we_i) begin
      cell_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = cell_q[raddr_i];
endmodule

// File: rtl/spc_seq.sv
module spc_seq
  import spc_pkg::*;
#(
  parameter int SECT_AW  = 3,
  parameter int LOAD_WIN = 20,
  parameter int PROG_CYC = 600  // must be >= 2*NB
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [SECT_AW-1:0] sect_i,
  input  logic               wmsb_i,
  output logic               buf_wr_o,
  output logic               buf_clr_o,
  output logic               arr_we_o,
  output logic               arr_pgm_o,
  output logic [BYTE_AW-1:0] arr_idx_o,
  output logic [SECT_AW-1:0] sect_o,
  output logic               busy_o,
  output logic               load_o,
  output logic               err_o,
  output logic               last_msb_o,
  output logic               tog_o
);
  localparam int LW    = $clog2(LOAD_WIN + 1);
  localparam int CW    = $clog2(PROG_CYC + 1);
  localparam int PASSW = 2 * NB;

  spc_state_e         state_q;
  logic [SECT_AW-1:0] sect_q;
  logic [LW-1:0]      load_cnt_q;
  logic [CW-1:0]      cyc_cnt_q;
  logic               last_msb_q, err_q, tog_q;
  logic               accept, foreign, cyc_last;

  assign accept   = we_i && ((state_q == ST_IDLE) ||
                             (state_q == ST_LOAD && sect_i == sect_q));
  assign foreign  = we_i && (state_q == ST_LOAD) && (sect_i != sect_q);
  assign cyc_last = (state_q == ST_PROG) && (cyc_cnt_q == CW'(PROG_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sect_q     <= '0;
      load_cnt_q <= '0;
      cyc_cnt_q  <= '0;
      last_msb_q <= 1'b0;
      err_q      <= 1'b0;
      tog_q      <= 1'b0;
    end else begin
      if (foreign) err_q <= 1'b1;
      if (accept)  last_msb_q <= wmsb_i;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            sect_q     <= sect_i;
            load_cnt_q <= '0;
            state_q    <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (accept) begin
            load_cnt_q <= '0;
          end else if (load_cnt_q == LW'(LOAD_WIN - 1)) begin
            state_q   <= ST_PROG;
            cyc_cnt_q <= '0;
            tog_q     <= 1'b0;
          end else begin
            load_cnt_q <= load_cnt_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (re_i) tog_q <= ~tog_q;
          if (cyc_last) state_q <= ST_IDLE;
          else          cyc_cnt_q <= cyc_cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // erase pass over the sector, then program pass
  assign arr_we_o   = (state_q == ST_PROG) && (cyc_cnt_q < CW'(PASSW));
  assign arr_pgm_o  = cyc_cnt_q[BYTE_AW];
  assign arr_idx_o  = cyc_cnt_q[BYTE_AW-1:0];
  assign buf_wr_o   = accept;
  assign buf_clr_o  = cyc_last;
  assign sect_o     = sect_q;
  assign busy_o     = (state_q == ST_PROG);
  assign load_o     = (state_q == ST_LOAD);
  assign err_o      = err_q;
  assign last_msb_o = last_msb_q;
  assign tog_o      = tog_q;

  a_r3_prog_from_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(load_o) && $past(load_cnt_q) == LW'(LOAD_WIN - 1));
  a_r4_cycle_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(cyc_cnt_q) == CW'(PROG_CYC - 1));
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r7_toggle_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && re_i && !cyc_last) |=> (tog_o != $past(tog_o)));
  a_r9_busy_msb_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cyc_last) |=> $stable(last_msb_o));
  a_r1_single_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && load_o));
endmodule

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl
  import spc_pkg::*;
#(
  parameter int SECT_AW  = 3,
  parameter int LOAD_WIN = 20,
  parameter int PROG_CYC = 600,
  localparam int AW      = SECT_AW + BYTE_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          busy_o,
  output logic          load_o,
  output logic          sect_err_o
);
  logic               buf_wr, buf_clr, arr_we, arr_pgm, last_msb, tog;
  logic [BYTE_AW-1:0] arr_idx;
  logic [SECT_AW-1:0] prog_sect;
  logic [DW-1:0]      buf_data, arr_rdata, prog_data;
  logic               buf_vld;
  logic [DW-1:0]      rdata_q;

  spc_seq #(
    .SECT_AW (SECT_AW),
    .LOAD_WIN(LOAD_WIN),
    .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .re_i      (re_i),
    .sect_i    (addr_i[AW-1:BYTE_AW]),
    .wmsb_i    (wdata_i[7]),
    .buf_wr_o  (buf_wr),
    .buf_clr_o (buf_clr),
    .arr_we_o  (arr_we),
    .arr_pgm_o (arr_pgm),
    .arr_idx_o (arr_idx),
    .sect_o    (prog_sect),
    .busy_o    (busy_o),
    .load_o    (load_o),
    .err_o     (sect_err_o),
    .last_msb_o(last_msb),
    .tog_o     (tog)
  );

  spc_sector_buf u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (buf_wr),
    .wr_idx_i  (addr_i[BYTE_AW-1:0]),
    .wr_data_i (wdata_i),
    .clr_i     (buf_clr),
    .rd_idx_i  (arr_idx),
    .rd_data_o (buf_data),
    .rd_valid_o(buf_vld)
  );

  assign prog_data = (arr_pgm && buf_vld) ? buf_data : '1;

  spc_flash_array #(.AW(AW)) u_arr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (arr_we),
    .waddr_i({prog_sect, arr_idx}),
    .wdata_i(prog_data),
    .raddr_i(addr_i),
    .rdata_o(arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= busy_o ? {~last_msb, tog, 6'b0} : arr_rdata;
  end
  assign rdata_o = rdata_q;

  a_r9_array_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we |-> busy_o);
  a_r9_no_stage_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !buf_wr);
  a_r5_unloaded_erased: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we && !buf_vld) |-> prog_data == 8'hFF);
  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  a_r1_open_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !busy_o && !load_o) |=> load_o);
  a_r6_status_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && busy_o) |=> rdata_o[5:0] == 6'b0);
endmodule

// File: tb/tb_sector_prog_ctrl.sv
module tb_sector_prog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SECT_AW    = 3;
  localparam int LOAD_WIN   = 20;
  localparam int PROG_CYC   = 600;
  localparam int AW         = SECT_AW + 8;
  localparam int NSECT      = 1 << SECT_AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we_i = 1'b0, re_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic          busy_o, load_o, sect_err_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [NSECT*256];
  logic [7:0] stage [256];
  bit         staged [256];
  logic [7:0] last_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_prog_ctrl #(.SECT_AW(SECT_AW), .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_o(busy_o), .load_o(load_o),
    .sect_err_o(sect_err_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ad(input int s, input int o);
    return s * 256 + o;
  endfunction

  function automatic logic [7:0] status_exp(input logic [7:0] d, input bit t);
    return {~d[7], t, 6'b0};
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    we_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    re_i = 1'b1; addr_i = AW'(a);
    @(negedge clk);
    re_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic stage_wr(input int s, input int o, input logic [7:0] d);
    wr(ad(s, o), d);
    stage[o] = d; staged[o] = 1'b1; last_d = d;
  endtask

  // called 'elapsed' negedges after the last accepted write
  task automatic finish_sector(input int s, input int elapsed, input bit busy_wr);
    logic [7:0] v;
    int cnt;
    bit t;
    repeat (LOAD_WIN - 1 - elapsed) @(negedge clk);
    chk(busy_o == 1'b0, "R3 window still open", busy_o, 0);
    @(negedge clk);
    chk(busy_o == 1'b1, "R3 cycle starts", busy_o, 1);
    cnt = 1; t = 1'b0;
    for (int k = 0; k < 4; k++) begin
      rd(ad(s, k), v);
      chk(v == status_exp(last_d, t), "R6 R7 status read", v, status_exp(last_d, t));
      t = ~t;
      cnt++;
    end
    if (busy_wr) begin
      wr(ad(s, 0), ~last_d);
      cnt++;
      rd(ad(s, 1), v);
      cnt++;
      chk(v[7] == ~last_d[7], "R9 status msb after busy write", v, status_exp(last_d, t));
    end
    forever begin
      @(negedge clk);
      if (busy_o) cnt++;
      else break;
    end
    chk(cnt == PROG_CYC, "R4 busy length", cnt, PROG_CYC);
    for (int o = 0; o < 256; o++) begin
      model[ad(s, o)] = staged[o] ? stage[o] : 8'hFF;
      staged[o] = 1'b0;
    end
  endtask

  task automatic verify_sector(input int s);
    logic [7:0] v;
    int os;
    for (int o = 0; o < 256; o++) begin
      rd(ad(s, o), v);
      chk(v == model[ad(s, o)], "R2 R5 readback", v, model[ad(s, o)]);
    end
    os = (s + 1 + int'($urandom_range(NSECT - 2))) % NSECT;
    for (int k = 0; k < 3; k++) begin
      int o = int'($urandom_range(255));
      rd(ad(os, o), v);
      chk(v == model[ad(os, o)], "R5 other sector kept", v, model[ad(os, o)]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NSECT * 256; i++) model[i] = 8'hFF;
    for (int o = 0; o < 256; o++) staged[o] = 1'b0;
    last_d = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(busy_o == 0 && load_o == 0 && sect_err_o == 0, "R10 flags", {busy_o, load_o, sect_err_o}, 0);
    chk(rdata_o == 8'h00, "R10 rdata", rdata_o, 0);
    rd(ad(4, 17), v);
    chk(v == 8'hFF, "R10 erased array", v, 8'hFF);
    @(negedge clk);
    chk(rdata_o == v, "R11 rdata held", rdata_o, v);

    // directed: any order, overwrite, window edge, busy write
    stage_wr(2, 5, 8'h80);
    chk(load_o == 1'b1, "R1 load opens", load_o, 1);
    repeat (LOAD_WIN - 1) @(negedge clk);
    chk(busy_o == 1'b0, "R3 gap at limit", busy_o, 0);
    stage_wr(2, 200, 8'h3C);
    stage_wr(2, 5, 8'h11);
    finish_sector(2, 0, 1'b1);
    chk(sect_err_o == 1'b0, "R9 no error on busy write", sect_err_o, 0);
    verify_sector(2);
    rd(ad(2, 200), v);
    rd(ad(2, 200), v2);
    chk(v == v2 && v == 8'h3C, "R7 no toggle when idle", v2, 8'h3C);

    // directed: foreign sector write during load
    stage_wr(6, 0, 8'hA5);
    wr(ad(1, 9), 8'h42);
    chk(sect_err_o == 1'b1, "R8 error set", sect_err_o, 1);
    finish_sector(6, 1, 1'b0);
    chk(sect_err_o == 1'b1, "R8 error sticky", sect_err_o, 1);
    verify_sector(6);
    rd(ad(1, 9), v);
    chk(v == model[ad(1, 9)], "R8 foreign byte dropped", v, model[ad(1, 9)]);

    // random loads
    for (int r = 0; r < 6; r++) begin
      int s = int'($urandom_range(NSECT - 1));
      int n = 1 + int'($urandom_range(15));
      for (int k = 0; k < n; k++) begin
        if (k != 0) begin
          repeat (int'($urandom_range(LOAD_WIN - 1))) @(negedge clk);
          chk(busy_o == 1'b0, "R3 load open before write", busy_o, 0);
        end
        stage_wr(s, int'($urandom_range(255)), 8'($urandom));
      end
      finish_sector(s, 0, r[0]);
      verify_sector(s);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule